// File: doc/BRIEF.md
# Signed Shift-by-One Unit with Exactness Flag

This combinational unit takes an 8-bit two's complement operand and a 2-bit operation code. It returns the operand unchanged, doubled, or halved. Doubling is a left shift by one place with a zero entering the low bit. Halving is an arithmetic right shift by one place, so the sign bit stays where it is and is also copied into the next bit down.

Alongside the result, the unit raises an error output whenever that result is not the exact arithmetic answer. When doubling, the error means the product would fall outside -128..127. When halving, it means the operand was odd, so a remainder was dropped. The result pins always show the plain shifted pattern, even when the error is raised. The caller decides whether to use the value or discard it.

Inside, a small decoder turns the code into strobes, and a bit-sliced datapath builds the result and the error. Both the data width and the code width are parameters. The default is 8 data bits.

Top module: `sshift_unit`

## Requirements
- R1: With opCode 2'b00, result equals operand and overflowErr is 0, for every operand.
- R2: Code 2'b01 is unused. It behaves exactly like 2'b00: result equals operand and overflowErr is 0.
- R3: With opCode 2'b10, result is the operand shifted left by one place, with bit 0 of the result equal to 0.
- R4: With opCode 2'b10, overflowErr is 1 exactly when operand bits 7 and 6 differ. For example, 8'b10100000 (-96) flags an error, 8'b11000100 (-60) gives 8'b10001000 (-120) with no error, and 8'b00110001 (49) gives 8'b01100010 (98) with no error.
- R5: With opCode 2'b11, result bit 7 equals operand bit 7, and result bits 6..0 equal operand bits 7..1.
- R6: With opCode 2'b11, overflowErr equals operand bit 0.
- R7: When overflowErr is 1, result still carries the plain shifted pattern. It is not saturated or corrected. For example, doubling 8'b01000000 gives 8'b10000000.
- R8: The outputs depend only on the present inputs. They settle without any clock edge and hold no state between inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand | input | 8 | Two's complement value to transform |
| opCode | input | 2 | 00 pass, 01 unused (pass), 10 double, 11 halve |
| result | output | 8 | Transformed value |
| overflowErr | output | 1 | Result is not exact (overflow on double, odd on halve) |

## Verification
Every one of the 256 operands is applied under each of the four codes. This separates the two pass codes from the shifting codes. It also separates doubling, where a zero fills bit 0, from halving, where the sign is copied into the upper bits.

Positive and negative values on both sides of the ±64 boundary show whether the doubling error follows the disagreement between the top two bits. Odd and even operands, combined with both signs, show whether the halving error follows only the low bit.

Fixed cases repeat the three worked doubling values and one overflowing value whose raw pattern must survive. Changing the inputs between clock edges shows that the outputs follow them with no clock.

// File: rtl/sshift_pkg.sv
package sshift_pkg;
  localparam int OP_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_PASS  = 2'b00,
    OP_SPARE = 2'b01,
    OP_DBL   = 2'b10,
    OP_HALF  = 2'b11
  } opSel_e;

  typedef struct packed {
    logic selDbl;
    logic selHalf;
    logic chkTopPair;
    logic chkLowBit;
  } ctrlStrobes_t;
endpackage

// File: rtl/sshift_ctrl.sv
module sshift_ctrl
  import sshift_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output ctrlStrobes_t    strobes
);
  opSel_e opSel;

  always_comb begin
    opSel   = opSel_e'(opCode);
    strobes = '0;
    unique case (opSel)
      OP_DBL: begin
        strobes.selDbl     = 1'b1;
        strobes.chkTopPair = 1'b1;
      end
      OP_HALF: begin
        strobes.selHalf   = 1'b1;
        strobes.chkLowBit = 1'b1;
      end
      OP_PASS, OP_SPARE: strobes = '0;
      default: strobes = '0;
    endcase
  end
endmodule

// File: rtl/sshift_datapath.sv
module sshift_datapath
  import sshift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] operand,
  input  ctrlStrobes_t     strobes,
  output logic [WIDTH-1:0] result,
  output logic             overflowErr
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] fromBelow;
  logic [WIDTH-1:0] fromAbove;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    if (i == 0) begin : g_low
      assign fromBelow[i] = 1'b0;
    end else begin : g_mid_lo
      assign fromBelow[i] = operand[i-1];
    end

    if (i == MSB) begin : g_top
      assign fromAbove[i] = operand[MSB];
    end else begin : g_mid_hi
      assign fromAbove[i] = operand[i+1];
    end

    always_comb begin
      if (strobes.selDbl)       result[i] = fromBelow[i];
      else if (strobes.selHalf) result[i] = fromAbove[i];
      else                      result[i] = operand[i];
    end
  end

  logic topPairSplit;
  logic lowBitSet;

  assign topPairSplit = operand[MSB] ^ operand[MSB-1];
  assign lowBitSet    = operand[0];
  assign overflowErr  = (strobes.chkTopPair & topPairSplit)
                      | (strobes.chkLowBit & lowBitSet);
endmodule

// File: rtl/sshift_unit.sv
module sshift_unit
  import sshift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] operand,
  input  logic [1:0]       opCode,
  output logic [WIDTH-1:0] result,
  output logic             overflowErr
);
  ctrlStrobes_t strobes;

  sshift_ctrl u_ctrl (
    .opCode  (opCode),
    .strobes (strobes)
  );

  sshift_datapath #(.WIDTH(WIDTH)) u_dp (
    .operand     (operand),
    .strobes     (strobes),
    .result      (result),
    .overflowErr (overflowErr)
  );
endmodule

// File: rtl/sshift_unit_chk.sv
module sshift_unit_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] operand,
  input logic [1:0]       opCode,
  input logic [WIDTH-1:0] result,
  input logic             overflowErr
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    if (!opCode[1]) begin
      a_r1_pass_identity: assert (result == operand && !overflowErr);
    end
    if (opCode == 2'b01) begin
      a_r2_spare_no_err: assert (!overflowErr);
    end
    if (opCode == 2'b10) begin
      a_r3_dbl_zero_fill: assert (result[0] == 1'b0);
      if (!overflowErr) begin
        a_r4_dbl_exact: assert ($signed(result) == $signed(operand) <<< 1);
      end
      if (overflowErr) begin
        a_r7_dbl_sign_flip: assert (result[MSB] != operand[MSB]);
      end
    end
    if (opCode == 2'b11) begin
      a_r5_half_sign_kept: assert (result[MSB] == operand[MSB]);
      if (!overflowErr) begin
        a_r6_half_exact: assert (({result, 1'b0}) == {operand[MSB], operand});
      end
    end
  end
endmodule

bind sshift_unit sshift_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .operand     (operand),
  .opCode      (opCode),
  .result      (result),
  .overflowErr (overflowErr)
);

// File: tb/tb_sshift_unit.sv
module tb_sshift_unit;
  logic       clk = 1'b0;
  logic [7:0] operand = 8'h00;
  logic [1:0] opCode = 2'b00;
  logic [7:0] result;
  logic       overflowErr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  sshift_unit dut (
    .operand     (operand),
    .opCode      (opCode),
    .result      (result),
    .overflowErr (overflowErr)
  );

  task automatic check(string req, logic [7:0] op, logic [1:0] code,
                       logic [7:0] expRes, logic expErr);
    nChecks++;
    if (result !== expRes || overflowErr !== expErr) begin
      nFails++;
      $display("FAIL %s op=%b code=%b actual res=%b err=%b expected res=%b err=%b",
               req, op, code, result, overflowErr, expRes, expErr);
    end
  endtask

  task automatic apply(logic [7:0] op, logic [1:0] code);
    @(negedge clk);
    operand = op;
    opCode  = code;
    #1;
  endtask

  // R1: pass code, every operand
  task automatic tPass();
    for (int v = 0; v < 256; v++) begin
      apply(8'(v), 2'b00);
      check("R1", 8'(v), 2'b00, 8'(v), 1'b0);
    end
  endtask

  // R2: unused code acts as pass
  task automatic tSpare();
    for (int v = 0; v < 256; v++) begin
      apply(8'(v), 2'b01);
      check("R2", 8'(v), 2'b01, 8'(v), 1'b0);
    end
  endtask

  // R3/R4/R7: double, with arithmetic range check
  task automatic tDouble();
    for (int v = -128; v < 128; v++) begin
      int prod = v * 2;
      logic e = (prod > 127) || (prod < -128);
      apply(8'(v), 2'b10);
      check(e ? "R4/R7" : "R3", 8'(v), 2'b10, 8'(prod), e);
    end
  endtask

  // R5/R6: halve with floor semantics, odd flagged
  task automatic tHalve();
    for (int v = -128; v < 128; v++) begin
      int q = (v - ((v % 2 + 2) % 2)) / 2;
      logic e = (v % 2) != 0;
      apply(8'(v), 2'b11);
      check(e ? "R6" : "R5", 8'(v), 2'b11, 8'(q), e);
    end
  endtask

  // R4/R7: worked values
  task automatic tExamples();
    apply(8'b10100000, 2'b10); check("R4", 8'b10100000, 2'b10, 8'b01000000, 1'b1);
    apply(8'b11000100, 2'b10); check("R4", 8'b11000100, 2'b10, 8'b10001000, 1'b0);
    apply(8'b00110001, 2'b10); check("R4", 8'b00110001, 2'b10, 8'b01100010, 1'b0);
    apply(8'b01000000, 2'b10); check("R7", 8'b01000000, 2'b10, 8'b10000000, 1'b1);
    apply(8'b10000001, 2'b11); check("R6", 8'b10000001, 2'b11, 8'b11000000, 1'b1);
  endtask

  // R8: inputs changed mid-cycle, outputs follow without an edge
  task automatic tComb();
    @(posedge clk);
    #1 operand = 8'h21; opCode = 2'b10;
    #1 check("R8", 8'h21, 2'b10, 8'h42, 1'b0);
    #1 opCode = 2'b11;
    #1 check("R8", 8'h21, 2'b11, 8'h10, 1'b1);
    #1 operand = 8'h7F; opCode = 2'b00;
    #1 check("R8", 8'h7F, 2'b00, 8'h7F, 1'b0);
  endtask

  initial begin
    #2;
    check("R1", 8'h00, 2'b00, 8'h00, 1'b0);
    tPass();
    tSpare();
    tDouble();
    tHalve();
    tExamples();
    tComb();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog expired actual=running expected=finished");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule